// File: doc/BRIEF.md
# Fall-Through FIFO Read Stage

This block is the read side of a small synchronous FIFO that runs in one of two modes chosen at reset. In standard mode the consumer must ask for each word: a word reaches the data output only on a clock edge where the active-low read enable is asserted, and an active-low flag reports that nothing is left to read. In fall-through mode the oldest word is pushed onto the data output without being asked for. The same active-low flag then means "the output holds a valid word", and each read consumes that word.

The storage array and its write pointer are included only so the read side has something to drain. The write pointer reaches the read logic through a fixed chain of registers that stands in for a clock-domain crossing. A new word therefore moves the flag after two read-clock edges in standard mode and after three in fall-through mode. In fall-through mode the output register counts as one more storage slot.

Top module: `fwft_read_stage`

## Requirements
- R1: While `rst_n` is LOW the FIFO is emptied and `rd_data` is 0. After reset `flag_n` is LOW in standard mode and HIGH in fall-through mode.
- R2: `mode_i` is sampled only while `rst_n` is LOW (0 = standard, 1 = fall-through). Changing it after reset has no effect.
- R3: Standard mode: after a write edge into an empty FIFO, `flag_n` goes HIGH at the second following rising edge. `rd_data` does not change.
- R4: Standard mode: an edge with `ren_n` LOW and `flag_n` HIGH loads the oldest word into `rd_data`. `flag_n` goes LOW at the edge that reads the last word. `ren_n` has no effect while `flag_n` is LOW.
- R5: Fall-through mode: after a write edge into an empty FIFO, the word appears on `rd_data` with `flag_n` LOW at the third following rising edge, with no read request.
- R6: Fall-through mode: `flag_n` goes from LOW to HIGH only at an edge with `ren_n` LOW. While `ren_n` is HIGH, `rd_data` and `flag_n` hold.
- R7: Fall-through mode: after the last word is read, that word stays on `rd_data` with `flag_n` HIGH. Further reads have no effect until a new word arrives.
- R8: Words leave the FIFO in the order they were written.
- R9: Capacity is DEPTH words in standard mode and DEPTH+1 in fall-through mode. Writes beyond capacity are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the read stage and the test write port |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | Mode select, sampled during reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write strobe into the storage array |
| wr_data | input | 9 | Word to store |
| ren_n | input | 1 | Active-low read enable |
| rd_data | output | 9 | Registered data output |
| flag_n | output | 1 | Empty flag in standard mode, output-ready flag in fall-through mode, both active LOW |

## Verification
The bench checks the flag latency of each mode down to the exact edge. A design that reused one latency for both modes would raise the flag an edge early or late.

It checks that a held-off read in fall-through mode keeps the presented word. It checks that reading past the last word leaves that word on the bus and the flag HIGH. A design that consumed a word without a read request, or underran the array, would show a wrong word.

Both modes are filled past capacity. A design that forgot the output register's extra slot, or let a write overwrite unread data, would return the wrong number of words or the wrong values. The mode pin is also toggled after reset, which exposes any design that samples it all the time.

// File: rtl/fwft_pkg.sv
// Package: fwft_pkg
// Shared types for the fall-through FIFO read stage.
package fwft_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,   // explicit-read mode
        MODE_FWFT = 1'b1    // fall-through mode
    } rd_mode_e;
endpackage

// File: rtl/fwft_store.sv
// Module: fwft_store
// Storage array with a write pointer and overflow protection.
// Assumes DEPTH is a power of two. Pointers carry one wrap bit.
// The read port is combinational, indexed by the read pointer.
module fwft_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [WIDTH-1:0]          wr_data,
    input  logic [$clog2(DEPTH):0]    rptr,
    output logic [$clog2(DEPTH):0]    wptr,
    output logic [WIDTH-1:0]          rd_word
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    used;
    logic             full;
    logic             accept;

    // Occupancy seen by the writer and the resulting acceptance decision.
    always_comb begin
        used   = wptr - rptr;
        full   = (used == PW'(DEPTH));
        accept = wr_en && !full;
    end

    // Advance the write pointer on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (accept) begin
            wptr <= wptr + PW'(1);
        end
    end

    // Store the accepted word.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wptr[AW-1:0]] <= wr_data;
        end
    end

    // Present the word at the read pointer.
    always_comb begin
        rd_word = mem[rptr[AW-1:0]];
    end
endmodule

// File: rtl/fwft_ptr_sync.sv
// Module: fwft_ptr_sync
// Fixed register chain that delays the write pointer before the
// read logic sees it, standing in for a clock-domain crossing.
// Assumes STAGES >= 1.
module fwft_ptr_sync #(
    parameter int PW     = 4,
    parameter int STAGES = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ptr_in,
    output logic [PW-1:0] ptr_out
);
    logic [PW-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One delay register of the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else if (s == 0) begin
                chain[s] <= ptr_in;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign ptr_out = chain[STAGES-1];
endmodule

// File: rtl/fwft_mode_latch.sv
// Module: fwft_mode_latch
// Captures the mode pin while reset is held and freezes it afterwards.
module fwft_mode_latch
    import fwft_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mode_i,
    output rd_mode_e mode_q
);
    // Sample the mode only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= rd_mode_e'(mode_i);
        end
    end
endmodule

// File: rtl/fwft_read_ctrl.sv
// Module: fwft_read_ctrl
// Read pointer, output register and flag for both modes.
// Standard mode: the flag follows the synchronised pointer one register
// later. Fall-through mode: an extra availability register sits before
// the output load, and the output register acts as a storage slot.
// Assumes wsync never runs ahead of the true write pointer.
module fwft_read_ctrl
    import fwft_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int PW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  rd_mode_e         mode_q,
    input  logic             ren_n,
    input  logic [PW-1:0]    wsync,
    input  logic [WIDTH-1:0] rd_word,
    output logic [PW-1:0]    rptr,
    output logic [WIDTH-1:0] rd_data,
    output logic             flag_n
);
    logic          avail_q;
    logic          std_read;
    logic          ff_load;
    logic          take;
    logic [PW-1:0] rptr_nxt;

    // Decide whether a word leaves the array this edge.
    always_comb begin
        std_read = (mode_q == MODE_STD) && !ren_n && flag_n;
        ff_load  = (mode_q == MODE_FWFT) && avail_q && (flag_n || !ren_n);
        take     = std_read || ff_load;
        rptr_nxt = rptr + {{(PW-1){1'b0}}, take};
    end

    // Read pointer, output word, flag and fall-through availability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            rd_data <= '0;
            avail_q <= 1'b0;
            flag_n  <= mode_i;
        end else begin
            rptr <= rptr_nxt;
            if (take) begin
                rd_data <= rd_word;
            end
            if (mode_q == MODE_STD) begin
                avail_q <= 1'b0;
                flag_n  <= (wsync != rptr_nxt);
            end else begin
                avail_q <= (wsync != rptr_nxt);
                if (ff_load) begin
                    flag_n <= 1'b0;
                end else if (!ren_n) begin
                    flag_n <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fwft_read_stage.sv
// Module: fwft_read_stage
// Top level: storage array, write-pointer delay chain, mode latch and
// read controller. One clock serves both sides; the delay chain models
// the crossing. Flag latency after a write is SYNC_STAGES+1 edges in
// standard mode and SYNC_STAGES+2 edges in fall-through mode.
module fwft_read_stage
    import fwft_pkg::*;
#(
    parameter int WIDTH       = 9,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ren_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             flag_n
);
    localparam int PW = $clog2(DEPTH) + 1;

    rd_mode_e         mode_q;
    logic [PW-1:0]    wptr;
    logic [PW-1:0]    wsync;
    logic [PW-1:0]    rptr;
    logic [WIDTH-1:0] rd_word;

    fwft_mode_latch u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .mode_q (mode_q)
    );

    fwft_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rptr    (rptr),
        .wptr    (wptr),
        .rd_word (rd_word)
    );

    fwft_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_in  (wptr),
        .ptr_out (wsync)
    );

    fwft_read_ctrl #(.WIDTH(WIDTH), .PW(PW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .mode_q  (mode_q),
        .ren_n   (ren_n),
        .wsync   (wsync),
        .rd_word (rd_word),
        .rptr    (rptr),
        .rd_data (rd_data),
        .flag_n  (flag_n)
    );
endmodule

// File: rtl/fwft_read_stage_chk.sv
// Module: fwft_read_stage_chk
// Assertion checker bound to fwft_read_stage.
module fwft_read_stage_chk
    import fwft_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst_n,
    input rd_mode_e         mode_q,
    input logic             ren_n,
    input logic [WIDTH-1:0] rd_data,
    input logic             flag_n
);
    // R2: latched mode never changes outside reset
    a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

    // R4: standard mode, read while empty leaves the output alone
    a_r4_std_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STD && !flag_n) |=> $stable(rd_data));

    // R4: standard mode, no read request means no output change
    a_r4_std_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STD && ren_n) |=> $stable(rd_data));

    // R6: fall-through mode, ready flag is released only by a real read
    a_r6_ready_kept_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FWFT && !flag_n && ren_n) |=> (!flag_n && $stable(rd_data)));

    // R7: fall-through mode, output holds while not ready
    a_r7_hold_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FWFT && flag_n) |=> (!flag_n || $stable(rd_data)));
endmodule

bind fwft_read_stage fwft_read_stage_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_q  (mode_q),
    .ren_n   (ren_n),
    .rd_data (rd_data),
    .flag_n  (flag_n)
);

// File: tb/sim_fwft_read_stage.sv
module sim_fwft_read_stage;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       ren_n = 1'b1;
    logic [8:0] rd_data;
    logic       flag_n;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fwft_read_stage #(.WIDTH(9), .DEPTH(8), .SYNC_STAGES(1)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_en(wr_en),
        .wr_data(wr_data), .ren_n(ren_n), .rd_data(rd_data), .flag_n(flag_n)
    );

    typedef struct packed {
        logic       wr;
        logic [8:0] wd;
        logic       rn;
        logic       ef;
        logic [8:0] ed;
    } vec_t;

    // Fall-through run from reset; each row is one edge, expectations after it.
    localparam vec_t VEC [16] = '{
        '{1'b1, 9'h1A1, 1'b1, 1'b1, 9'h000},  // R5 write A
        '{1'b1, 9'h0B2, 1'b1, 1'b1, 9'h000},  // R5 write B
        '{1'b0, 9'h000, 1'b1, 1'b1, 9'h000},  // R5 not yet
        '{1'b0, 9'h000, 1'b1, 1'b0, 9'h1A1},  // R5 third edge: A falls through
        '{1'b0, 9'h000, 1'b1, 1'b0, 9'h1A1},  // R6 no read, hold
        '{1'b0, 9'h000, 1'b0, 1'b0, 9'h0B2},  // R8 read A, B shown
        '{1'b0, 9'h000, 1'b0, 1'b1, 9'h0B2},  // R7 read B, B stays
        '{1'b0, 9'h000, 1'b0, 1'b1, 9'h0B2},  // R7 extra read blocked
        '{1'b1, 9'h155, 1'b1, 1'b1, 9'h0B2},
        '{1'b0, 9'h000, 1'b1, 1'b1, 9'h0B2},
        '{1'b0, 9'h000, 1'b1, 1'b1, 9'h0B2},
        '{1'b0, 9'h000, 1'b1, 1'b0, 9'h155},  // R5 C presented
        '{1'b1, 9'h0D4, 1'b0, 1'b1, 9'h155},  // R6 read C with write D
        '{1'b0, 9'h000, 1'b1, 1'b1, 9'h155},
        '{1'b0, 9'h000, 1'b1, 1'b1, 9'h155},
        '{1'b0, 9'h000, 1'b1, 1'b0, 9'h0D4}   // R8 D presented
    };

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got flag/data %b/%h expected %b/%h",
                     req, act[9], act[8:0], exp[9], exp[8:0]);
        end
    endtask

    task automatic step(input logic w, input logic [8:0] d, input logic r);
        @(negedge clk);
        wr_en = w; wr_data = d; ren_n = r;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0; mode_i = m; wr_en = 1'b0; ren_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // Fall-through table
        do_reset(1'b1);
        check("R1 fwft reset", {flag_n, rd_data}, {1'b1, 9'h000});
        for (int i = 0; i < 16; i++) begin
            step(VEC[i].wr, VEC[i].wd, VEC[i].rn);
            check($sformatf("R5/R6/R7/R8 row %0d", i), {flag_n, rd_data}, {VEC[i].ef, VEC[i].ed});
        end

        // Standard mode, then mode pin changed after reset (R2)
        do_reset(1'b0);
        check("R1 std reset", {flag_n, rd_data}, {1'b0, 9'h000});
        mode_i = 1'b1;
        step(1'b0, 9'h000, 1'b0);
        check("R4 read while empty ignored", {flag_n, rd_data}, {1'b0, 9'h000});
        step(1'b1, 9'h0AA, 1'b1);
        check("R3 flag after write edge", {flag_n, rd_data}, {1'b0, 9'h000});
        step(1'b0, 9'h000, 1'b1);
        check("R3 flag one edge later", {flag_n, rd_data}, {1'b0, 9'h000});
        step(1'b0, 9'h000, 1'b1);
        check("R3 R2 flag high, no fall-through", {flag_n, rd_data}, {1'b1, 9'h000});
        step(1'b0, 9'h000, 1'b0);
        check("R4 read last word", {flag_n, rd_data}, {1'b0, 9'h0AA});
        step(1'b0, 9'h000, 1'b0);
        check("R4 read when empty ignored", {flag_n, rd_data}, {1'b0, 9'h0AA});

        // Standard capacity: 10 writes, 8 kept (R9, R8)
        for (int i = 0; i < 10; i++) step(1'b1, 9'h100 + 9'(i), 1'b1);
        repeat (3) step(1'b0, 9'h000, 1'b1);
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 9'h000, 1'b0);
            check($sformatf("R8 R9 std word %0d", i), {flag_n, rd_data},
                  {(i == 7) ? 1'b0 : 1'b1, 9'h100 + 9'(i)});
        end
        step(1'b0, 9'h000, 1'b0);
        check("R9 std no ninth word", {flag_n, rd_data}, {1'b0, 9'h107});

        // Fall-through capacity: 10 writes, 9 kept (R9, R7)
        do_reset(1'b1);
        for (int i = 0; i < 10; i++) step(1'b1, 9'h040 + 9'(i), 1'b1);
        repeat (4) step(1'b0, 9'h000, 1'b1);
        for (int i = 0; i < 9; i++) begin
            check($sformatf("R9 fwft word %0d", i), {flag_n, rd_data}, {1'b0, 9'h040 + 9'(i)});
            step(1'b0, 9'h000, 1'b0);
        end
        check("R7 R9 last word held", {flag_n, rd_data}, {1'b1, 9'h048});
        step(1'b0, 9'h000, 1'b0);
        check("R7 read after last blocked", {flag_n, rd_data}, {1'b1, 9'h048});

        finish_run();
    end
endmodule